// File: doc/BRIEF.md
# Single-Cell Charge Phase Sequencer

This block is the digital controller of a single-cell battery charger. It never measures a voltage or a current. Its inputs are comparator decisions that have already been digitized, level pins from the board, a chemistry selection bit and a slow time-base tick. From these it chooses the charge phase and drives four things: the charge-enable, a constant-voltage select for the analog regulation loop, a fault flag and two active-low indicator LEDs (red and green).

Every level input passes through a two-flop synchronizer before the state machine uses it. Three conditions are checked ahead of any phase logic, in this order: supply health, then the enable pin, then the LDO select. When all three allow charging, a Li-ion cycle moves through its phases:

- PREQ: trickle pre-qualification.
- CC: constant current.
- CV: constant voltage.
- MAINT: maintenance, where the battery is watched for a restart.

A safety timer counts time-base ticks, but only while the phase is CC. When it expires, the controller either latches a fault or falls into maintenance, depending on a pin. Setting the chemistry bit selects a Ni-MH cycle instead. That cycle is constant-voltage only and has neither termination nor a timer.

The states and their phase codes are: OFF=0, DISABLED=1, LDO=2, PREQ=3, CC=4, CV=5, MAINT=6, FAULT=7, NIMH_CV=8.

The transitions are:

- **supply-loss**: any state goes to OFF.
- **disable**: any state goes to DISABLED.
- **ldo-select**: any state goes to LDO.
- **start**: OFF, DISABLED or LDO goes to PREQ, or to NIMH_CV.
- **qualify**: PREQ goes to CC.
- **reach-reg**: CC goes to CV.
- **terminate**: CV goes to MAINT.
- **restart**: MAINT goes to PREQ.
- **timeout-stop**: CC goes to FAULT.
- **timeout-bypass**: CC goes to MAINT.

Top module: `charge_sequencer`

## Requirements
- R1: If adapter_ok is low, or uv_lock is high, or ov_lock is high, the controller goes from any state to OFF (phase 0). In OFF, charge_en is 0 and both LED outputs are 1 (off).
- R2: If the supply is good and enable is low, the phase is DISABLED (1). In DISABLED, charge_en is 0, led_grn_n is 0 and led_red_n is 1.
- R3: If the supply is good, enable is high and ldo_sel is high, the phase is LDO (2). In LDO, charge_en is 0 and both LED outputs are 1.
- R4: If none of R1 to R3 applies and nimh_mode is 0, the controller leaves OFF, DISABLED or LDO for PREQ (3). In PREQ, charge_en is 1, cv_sel is 0, led_red_n is 0 and led_grn_n is 1.
- R5: PREQ moves to CC (4) when batt_above_preq is high. In CC, charge_en is 1 and cv_sel is 0.
- R6: CC moves to CV (5) when batt_at_reg is high. In CV, charge_en is 1 and cv_sel is 1.
- R7: CV moves to MAINT (6) when chg_below_term is high. In MAINT, charge_en is 0, led_grn_n is 0 and led_red_n is 1.
- R8: MAINT moves to PREQ (3) when batt_below_rst is high. From then on, the charging phases show led_grn_n=0 and led_red_n=1 until the controller next passes through OFF, DISABLED or LDO.
- R9: The safety timer counts time_tick pulses only while the phase is CC, and it clears whenever CC is left. On the TIMEOUT_TICKS-th tick in CC with timeout_stop high, the phase becomes FAULT (7). In FAULT, fault is 1, charge_en is 0 and both LED outputs are 0. FAULT holds until R1, R2 or R3 applies.
- R10: When the timer expires with timeout_stop low, CC moves to MAINT (6) instead of FAULT.
- R11: If the timer expires in the same cycle in which batt_at_reg is seen high, the timeout decides the next state. CV is not entered.
- R12: With nimh_mode 1, the start transition goes to NIMH_CV (8). In NIMH_CV, charge_en is 1, cv_sel is 1, led_red_n is 0 and led_grn_n is 1. NIMH_CV ignores chg_below_term and time_tick.
- R13: A change on a level input affects the state on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapter_ok | input | 1 | Adapter voltage within its operating window |
| uv_lock | input | 1 | Under-voltage lockout active |
| ov_lock | input | 1 | Over-voltage lockout active |
| enable | input | 1 | Charger enable pin |
| ldo_sel | input | 1 | High: battery absent, run as a plain regulator |
| timeout_stop | input | 1 | High: timer expiry faults; low: expiry goes to maintenance |
| nimh_mode | input | 1 | Chemistry select, 1 = Ni-MH |
| batt_above_preq | input | 1 | Battery above the pre-qualification level |
| batt_at_reg | input | 1 | Battery at the selected regulation level |
| batt_below_rst | input | 1 | Battery below the restart level |
| chg_below_term | input | 1 | Charge current below the end-of-charge threshold |
| time_tick | input | 1 | Single-cycle time-base pulse, already synchronous |
| phase | output | 4 | Current state code |
| charge_en | output | 1 | Enables the charge pass device |
| cv_sel | output | 1 | Selects voltage regulation instead of current regulation |
| fault | output | 1 | Safety-timer fault latched |
| led_red_n | output | 1 | Red indicator, active low |
| led_grn_n | output | 1 | Green indicator, active low |

## Verification
Two things can fall due in the same cycle: the safety-timer expiry and the regulation-reached flag arriving in CC. The bench raises batt_at_reg and then times the final time_tick so that it is high on exactly the clock edge where the synchronized flag first reaches the state machine. The run passes only if the next phase is FAULT with timeout_stop high, or MAINT with timeout_stop low, and never CV.

// File: rtl/chg_seq_pkg.sv
`timescale 1ns/1ps
package chg_seq_pkg;
    typedef enum logic [3:0] {
        ST_OFF      = 4'd0,
        ST_DISABLED = 4'd1,
        ST_LDO      = 4'd2,
        ST_PREQ     = 4'd3,
        ST_CC       = 4'd4,
        ST_CV       = 4'd5,
        ST_MAINT    = 4'd6,
        ST_FAULT    = 4'd7,
        ST_NIMH_CV  = 4'd8
    } chg_state_t;

    // bit positions inside the synchronized input bundle
    localparam int IX_ADP   = 0;
    localparam int IX_UV    = 1;
    localparam int IX_OV    = 2;
    localparam int IX_EN    = 3;
    localparam int IX_LDO   = 4;
    localparam int IX_STOP  = 5;
    localparam int IX_NIMH  = 6;
    localparam int IX_PREQ  = 7;
    localparam int IX_REG   = 8;
    localparam int IX_RST   = 9;
    localparam int IX_TERM  = 10;
    localparam int IN_W     = 11;
endpackage

// File: rtl/chg_sync.sv
`timescale 1ns/1ps
module chg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/chg_safety_timer.sv
`timescale 1ns/1ps
module chg_safety_timer #(
    parameter int TICKS = 20160
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    output logic            expire,
    output logic [$clog2(TICKS+1)-1:0] count
);
    localparam int CW = $clog2(TICKS+1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    assign expire = run && tick && (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (!run || expire)   count <= '0;
        else if (tick)             count <= count + 1'b1;
    end
endmodule

// File: rtl/chg_seq_fsm.sv
`timescale 1ns/1ps
module chg_seq_fsm
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       en,
    input  logic       ldo,
    input  logic       stop,
    input  logic       nimh,
    input  logic       above_preq,
    input  logic       at_reg,
    input  logic       below_rst,
    input  logic       below_term,
    input  logic       expire,
    output logic       timer_run,
    output logic [3:0] phase,
    output logic       charge_en,
    output logic       cv_sel,
    output logic       fault,
    output logic       led_red_n,
    output logic       led_grn_n
);
    chg_state_t st, nxt;
    logic       was_maint;
    logic       nxt_idle;

    always_comb begin
        nxt = st;
        if (!supply_ok)      nxt = ST_OFF;
        else if (!en)        nxt = ST_DISABLED;
        else if (ldo)        nxt = ST_LDO;
        else begin
            unique case (st)
                ST_OFF, ST_DISABLED, ST_LDO:
                    nxt = nimh ? ST_NIMH_CV : ST_PREQ;
                ST_PREQ:
                    if (above_preq) nxt = ST_CC;
                ST_CC:
                    if (expire)      nxt = stop ? ST_FAULT : ST_MAINT;
                    else if (at_reg) nxt = ST_CV;
                ST_CV:
                    if (below_term) nxt = ST_MAINT;
                ST_MAINT:
                    if (below_rst) nxt = ST_PREQ;
                ST_FAULT, ST_NIMH_CV:
                    nxt = st;
                default:
                    nxt = ST_OFF;
            endcase
        end
    end

    assign nxt_idle = (nxt == ST_OFF) || (nxt == ST_DISABLED) || (nxt == ST_LDO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_OFF;
            was_maint <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt == ST_MAINT) was_maint <= 1'b1;
            else if (nxt_idle)   was_maint <= 1'b0;
        end
    end

    always_comb begin
        charge_en = 1'b0;
        cv_sel    = 1'b0;
        fault     = 1'b0;
        led_red_n = 1'b1;
        led_grn_n = 1'b1;
        unique case (st)
            ST_OFF, ST_LDO: ;
            ST_DISABLED: led_grn_n = 1'b0;
            ST_PREQ, ST_CC, ST_CV: begin
                charge_en = 1'b1;
                cv_sel    = (st == ST_CV);
                led_red_n = was_maint;
                led_grn_n = !was_maint;
            end
            ST_MAINT: led_grn_n = 1'b0;
            ST_FAULT: begin
                fault     = 1'b1;
                led_red_n = 1'b0;
                led_grn_n = 1'b0;
            end
            ST_NIMH_CV: begin
                charge_en = 1'b1;
                cv_sel    = 1'b1;
                led_red_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign timer_run = (st == ST_CC);
    assign phase     = st;
endmodule

// File: rtl/charge_sequencer.sv
`timescale 1ns/1ps
module charge_sequencer
    import chg_seq_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 20160,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adapter_ok,
    input  logic       uv_lock,
    input  logic       ov_lock,
    input  logic       enable,
    input  logic       ldo_sel,
    input  logic       timeout_stop,
    input  logic       nimh_mode,
    input  logic       batt_above_preq,
    input  logic       batt_at_reg,
    input  logic       batt_below_rst,
    input  logic       chg_below_term,
    input  logic       time_tick,
    output logic [3:0] phase,
    output logic       charge_en,
    output logic       cv_sel,
    output logic       fault,
    output logic       led_red_n,
    output logic       led_grn_n
);
    localparam int CW = $clog2(TIMEOUT_TICKS+1);

    logic [IN_W-1:0] raw_in, syn_in;
    logic            supply_ok_s;
    logic            tmr_run, tmr_expire;
    logic [CW-1:0]   tmr_cnt;

    always_comb begin
        raw_in           = '0;
        raw_in[IX_ADP]   = adapter_ok;
        raw_in[IX_UV]    = uv_lock;
        raw_in[IX_OV]    = ov_lock;
        raw_in[IX_EN]    = enable;
        raw_in[IX_LDO]   = ldo_sel;
        raw_in[IX_STOP]  = timeout_stop;
        raw_in[IX_NIMH]  = nimh_mode;
        raw_in[IX_PREQ]  = batt_above_preq;
        raw_in[IX_REG]   = batt_at_reg;
        raw_in[IX_RST]   = batt_below_rst;
        raw_in[IX_TERM]  = chg_below_term;
    end

    chg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign supply_ok_s = syn_in[IX_ADP] && !syn_in[IX_UV] && !syn_in[IX_OV];

    chg_safety_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .tick(time_tick),
        .expire(tmr_expire), .count(tmr_cnt)
    );

    chg_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .supply_ok(supply_ok_s),
        .en(syn_in[IX_EN]),
        .ldo(syn_in[IX_LDO]),
        .stop(syn_in[IX_STOP]),
        .nimh(syn_in[IX_NIMH]),
        .above_preq(syn_in[IX_PREQ]),
        .at_reg(syn_in[IX_REG]),
        .below_rst(syn_in[IX_RST]),
        .below_term(syn_in[IX_TERM]),
        .expire(tmr_expire),
        .timer_run(tmr_run),
        .phase(phase),
        .charge_en(charge_en),
        .cv_sel(cv_sel),
        .fault(fault),
        .led_red_n(led_red_n),
        .led_grn_n(led_grn_n)
    );
endmodule

// File: rtl/chg_seq_chk.sv
`timescale 1ns/1ps
module chg_seq_chk #(
    parameter int TICKS = 20160
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [3:0]                 phase,
    input logic                       charge_en,
    input logic                       supply_ok_s,
    input logic                       en_s,
    input logic                       ldo_s,
    input logic                       stop_s,
    input logic                       above_s,
    input logic                       expire,
    input logic [$clog2(TICKS+1)-1:0] tmr_cnt
);
    // R1
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_s |=> phase == 4'd0);

    // R2
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok_s && !en_s) |=> (phase == 4'd1 && !charge_en));

    // R3
    ldo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok_s && en_s && ldo_s) |=> (phase == 4'd2 && !charge_en));

    // R5
    qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd4 && $past(phase) == 4'd3) |-> $past(above_s));

    // R9
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd7 && $past(phase) != 4'd7) |-> $past(expire && stop_s));

    // R9
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tmr_cnt) < TICKS);

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !stop_s && supply_ok_s && en_s && !ldo_s) |=> phase == 4'd6);
endmodule

bind charge_sequencer chg_seq_chk #(.TICKS(TIMEOUT_TICKS)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .phase(phase),
    .charge_en(charge_en),
    .supply_ok_s(supply_ok_s),
    .en_s(syn_in[3]),
    .ldo_s(syn_in[4]),
    .stop_s(syn_in[5]),
    .above_s(syn_in[7]),
    .expire(tmr_expire),
    .tmr_cnt(tmr_cnt)
);

// File: tb/test_charge_sequencer.sv
`timescale 1ns/1ps
module test_charge_sequencer;
    localparam int TICKS = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adapter_ok = 0, uv_lock = 0, ov_lock = 0, enable = 0, ldo_sel = 0;
    logic timeout_stop = 1, nimh_mode = 0;
    logic batt_above_preq = 0, batt_at_reg = 0, batt_below_rst = 0, chg_below_term = 0;
    logic time_tick = 0;
    logic [3:0] phase;
    logic charge_en, cv_sel, fault, led_red_n, led_grn_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    charge_sequencer #(.TIMEOUT_TICKS(TICKS)) i_charge_sequencer (
        .clk(clk), .rst_n(rst_n),
        .adapter_ok(adapter_ok), .uv_lock(uv_lock), .ov_lock(ov_lock),
        .enable(enable), .ldo_sel(ldo_sel), .timeout_stop(timeout_stop),
        .nimh_mode(nimh_mode), .batt_above_preq(batt_above_preq),
        .batt_at_reg(batt_at_reg), .batt_below_rst(batt_below_rst),
        .chg_below_term(chg_below_term), .time_tick(time_tick),
        .phase(phase), .charge_en(charge_en), .cv_sel(cv_sel), .fault(fault),
        .led_red_n(led_red_n), .led_grn_n(led_grn_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // packs {phase, charge_en, cv_sel, fault, red_n, grn_n}
    function automatic int outs();
        return {phase, charge_en, cv_sel, fault, led_red_n, led_grn_n};
    endfunction

    function automatic int pack(input int ph, input int ce, input int cv,
                                input int ft, input int rn, input int gn);
        return (ph << 5) | (ce << 4) | (cv << 3) | (ft << 2) | (rn << 1) | gn;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tick();
        time_tick = 1;
        @(negedge clk);
        time_tick = 0;
    endtask

    task automatic go_off();
        adapter_ok = 0;
        settle();
    endtask

    // brings a Li-ion cycle into CC with a cleared timer
    task automatic enter_cc();
        go_off();
        batt_above_preq = 0; batt_at_reg = 0; batt_below_rst = 0; chg_below_term = 0;
        nimh_mode = 0; ldo_sel = 0; enable = 1; uv_lock = 0; ov_lock = 0;
        adapter_ok = 1;
        settle();
        batt_above_preq = 1;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", outs(), pack(0, 0, 0, 0, 1, 1));
        rst_n = 1;
        settle();

        // R1 R2 R3 R4 R12: sweep over gate inputs and chemistry
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 32; v++) begin
                int exp_ph, exp_o;
                bit sup;
                go_off();
                nimh_mode = m[0];
                batt_above_preq = 0;
                {adapter_ok, uv_lock, ov_lock, enable, ldo_sel} = v[4:0];
                settle();
                sup = adapter_ok && !uv_lock && !ov_lock;
                if (!sup)          exp_o = pack(0, 0, 0, 0, 1, 1);
                else if (!enable)  exp_o = pack(1, 0, 0, 0, 1, 0);
                else if (ldo_sel)  exp_o = pack(2, 0, 0, 0, 1, 1);
                else if (m == 1)   exp_o = pack(8, 1, 1, 0, 0, 1);
                else               exp_o = pack(3, 1, 0, 0, 0, 1);
                exp_ph = exp_o;
                chk("R1/R2/R3/R4/R12 gate sweep", outs(), exp_ph);
            end
        end

        // R13: latency of a level input
        go_off();
        nimh_mode = 0; uv_lock = 0; ov_lock = 0; enable = 1; ldo_sel = 0;
        batt_above_preq = 0;
        adapter_ok = 1;
        settle();
        chk("R13 prior PREQ", phase, 3);
        adapter_ok = 0;
        repeat (2) @(negedge clk);
        chk("R13 not yet after two edges", phase, 3);
        @(negedge clk);
        chk("R13 OFF on third edge", phase, 0);

        // R5 R6 R7 R8: full Li-ion cycle
        enter_cc();
        chk("R5 CC outputs", outs(), pack(4, 1, 0, 0, 0, 1));
        batt_at_reg = 1;
        settle();
        chk("R6 CV outputs", outs(), pack(5, 1, 1, 0, 0, 1));
        chg_below_term = 1;
        settle();
        chk("R7 MAINT outputs", outs(), pack(6, 0, 0, 0, 1, 0));
        chg_below_term = 0; batt_at_reg = 0; batt_above_preq = 0;
        settle();
        chk("R8 MAINT holds without restart flag", phase, 6);
        batt_below_rst = 1;
        settle();
        chk("R8 restart to PREQ green", outs(), pack(3, 1, 0, 0, 1, 0));
        batt_below_rst = 0;
        batt_above_preq = 1;
        settle();
        chk("R8 CC after maintenance green", outs(), pack(4, 1, 0, 0, 1, 0));
        enable = 0;
        settle();
        enable = 1;
        batt_above_preq = 0;
        settle();
        chk("R8 flag cleared by DISABLED", outs(), pack(3, 1, 0, 0, 0, 1));

        // R9: timeout with stop pin high, and clearing on exit
        timeout_stop = 1;
        enter_cc();
        for (int k = 0; k < 4; k++) pulse_tick();
        chk("R9 CC after partial count", phase, 4);
        enable = 0;
        settle();
        enable = 1;
        settle();
        chk("R9 back in CC", phase, 4);
        for (int k = 0; k < TICKS - 1; k++) pulse_tick();
        chk("R9 timer cleared on exit", phase, 4);
        pulse_tick();
        chk("R9 FAULT outputs", outs(), pack(7, 0, 0, 1, 0, 0));
        batt_at_reg = 1; batt_below_rst = 1;
        settle();
        chk("R9 FAULT holds", phase, 7);
        ldo_sel = 1;
        settle();
        chk("R9 FAULT left by LDO select", phase, 2);
        ldo_sel = 0; batt_at_reg = 0; batt_below_rst = 0;

        // R10: timeout with stop pin low
        timeout_stop = 0;
        enter_cc();
        for (int k = 0; k < TICKS - 1; k++) pulse_tick();
        chk("R10 CC before last tick", phase, 4);
        pulse_tick();
        chk("R10 bypass into MAINT", outs(), pack(6, 0, 0, 0, 1, 0));

        // R11: expiry coinciding with regulation flag, both pin settings
        for (int s = 0; s < 2; s++) begin
            timeout_stop = s[0];
            enter_cc();
            for (int k = 0; k < TICKS - 1; k++) pulse_tick();
            batt_at_reg = 1;
            repeat (2) @(negedge clk);
            pulse_tick();
            chk("R11 timeout wins over regulation", phase, (s == 1) ? 7 : 6);
            batt_at_reg = 0;
        end

        // R12: Ni-MH ignores termination and ticks
        go_off();
        timeout_stop = 1; nimh_mode = 1; enable = 1; ldo_sel = 0;
        adapter_ok = 1;
        settle();
        chg_below_term = 1; batt_above_preq = 1; batt_at_reg = 1;
        settle();
        for (int k = 0; k < 2 * TICKS; k++) pulse_tick();
        chk("R12 NIMH_CV holds", outs(), pack(8, 1, 1, 0, 0, 1));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule